// File: doc/BRIEF.md
# Oversampled Bit Clock Recovery

This block recovers a bit clock and retimed data from a return-to-zero pulse stream. It runs on a reference clock at 48 times the nominal bit rate. That rate stands for three sampling clocks at 16 times the bit rate, spaced a third of a bit apart. A phase counter stepping through 48 positions marks one bit period. Only the rising edges of incoming pulses (ones) carry timing. Each accepted edge nudges the counter by at most one position, so that the edges come to fall on position 0. Zeros leave the counter free-running.

The recovered clock is high for the first half of the counter cycle and low for the second half. A one-cycle strobe marks the cycle in which a new retimed bit appears. The bit is 1 when a pulse edge arrived in the window centred on position 0. When loss of signal is flagged, the counter free-runs at the reference rate, pulse edges are ignored and the data output is held low.

Top module: `ones_clk_recover`

## Requirements
- R1: While reset is asserted, the phase is 0, the recovered clock is high, and the data and strobe outputs are 0.
- R2: In a cycle with no accepted rising edge, the phase advances by one and wraps from 47 to 0.
- R3: A rising edge accepted while the phase is between 1 and 23 holds the phase, so the next phase equals the current one.
- R4: A rising edge accepted while the phase is between 24 and 47 advances the phase by two, modulo 48. An edge at phase 0 gives a normal single step. A periodic pulse stream therefore locks with its edges at phase 0.
- R5: Only a 0-to-1 transition of the pulse input, between two consecutive reference cycles, counts as an edge. A level held high gives no further corrections, and zeros give none.
- R6: The recovered clock output is high exactly when the phase output is below 24.
- R7: The strobe output is high for exactly one cycle after each cycle in which the phase was 24.
- R8: When the strobe rises, the data output takes a new value and then holds it until the next strobe. The value is 1 if an edge was accepted in the window that starts at the previous phase-24 cycle and ends at the last phase-23 cycle. An edge in the phase-24 cycle itself belongs to the next window.
- R9: While loss of signal is high, pulse edges are ignored, the phase advances by one every cycle, and the data output is 0 from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock at 48x the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| pulse_in | input | 1 | Return-to-zero pulse stream, synchronous to clk |
| los_in | input | 1 | Loss-of-signal flag |
| rclk | output | 1 | Recovered bit clock, high for phases 0 to 23 |
| bit_stb | output | 1 | One-cycle strobe marking a new retimed bit |
| rdata | output | 1 | Retimed data bit |
| phase | output | 6 | Current sampling phase, 0 to 47 |

## Verification
The bench builds the block with its defaults: 16 sub-phases per sampling clock and three clocks, for 48 phases. At this size a pulse edge can be placed at each of the 48 phases in turn. Every hold, skip and wrap of the counter is then reached and compared cycle by cycle with a model in the bench. Runs of a held-high level, a misaligned periodic stream with zero bits mixed in, and a long loss-of-signal stretch cover locking, retimed data and free-running.

// File: rtl/ocr_pkg.sv
package ocr_pkg;
    // Correction applied to the phase counter on an accepted pulse edge.
    typedef enum logic [1:0] {
        ADJ_NONE = 2'd0,
        ADJ_HOLD = 2'd1,
        ADJ_SKIP = 2'd2
    } adj_e;
endpackage

// File: rtl/ocr_edge_det.sv
module ocr_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_in,
    input  logic los_in,
    output logic rise_o
);
    typedef struct packed {
        logic level;
    } edg_t;

    edg_t edg_d, edg_q;

    always_comb begin
        edg_d       = edg_q;
        edg_d.level = pulse_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) edg_q <= '0;
        else        edg_q <= edg_d;
    end

    // Only a low-to-high step counts, and none while the signal is lost.
    assign rise_o = pulse_in & ~edg_q.level & ~los_in;

    // R5
    no_double_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/ocr_phase_trk.sv
module ocr_phase_trk
    import ocr_pkg::*;
#(
    parameter int PHASES = 48
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rise_i,
    output logic [$clog2(PHASES)-1:0] phase_o,
    output logic                      rclk_o
);
    localparam int PW   = $clog2(PHASES);
    localparam int HALF = PHASES / 2;
    localparam logic [PW-1:0] HALF_P = PW'(HALF);

    typedef struct packed {
        logic [PW-1:0] phase;
        logic          rclk;
        logic          armed;
    } trk_t;

    trk_t trk_d, trk_q;
    adj_e adj;

    function automatic logic [PW-1:0] wrap_add(input logic [PW-1:0] p, input int k);
        int s;
        s = int'(p) + k;
        if (s >= PHASES) s = s - PHASES;
        return PW'(s);
    endfunction

    always_comb begin
        adj = ADJ_NONE;
        if (rise_i && trk_q.phase != '0)
            adj = (trk_q.phase < HALF_P) ? ADJ_HOLD : ADJ_SKIP;

        trk_d       = trk_q;
        trk_d.armed = 1'b1;
        case (adj)
            ADJ_HOLD: trk_d.phase = trk_q.phase;
            ADJ_SKIP: trk_d.phase = wrap_add(trk_q.phase, 2);
            default:  trk_d.phase = wrap_add(trk_q.phase, 1);
        endcase
        trk_d.rclk = (trk_d.phase < HALF_P);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q.phase <= '0;
            trk_q.rclk  <= 1'b1;
            trk_q.armed <= 1'b0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign phase_o = trk_q.phase;
    assign rclk_o  = trk_q.rclk;

    // R2
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_o < PW'(PHASES));

    // R2
    free_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trk_q.armed && !$past(rise_i) |-> phase_o == wrap_add($past(phase_o), 1));

    // R3
    late_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trk_q.armed && $past(rise_i) && $past(phase_o) != '0 && $past(phase_o) < HALF_P
        |-> phase_o == $past(phase_o));

    // R6
    clk_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trk_q.armed && $fell(rclk_o) |-> phase_o == HALF_P);
endmodule

// File: rtl/ocr_retime.sv
module ocr_retime #(
    parameter int PHASES = 48
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rise_i,
    input  logic                      los_in,
    input  logic [$clog2(PHASES)-1:0] phase_i,
    output logic                      rdata_o,
    output logic                      stb_o
);
    localparam int PW = $clog2(PHASES);
    localparam logic [PW-1:0] HALF_P = PW'(PHASES / 2);

    typedef struct packed {
        logic seen;
        logic rdata;
        logic stb;
        logic armed;
    } rt_t;

    rt_t rt_d, rt_q;

    always_comb begin
        rt_d       = rt_q;
        rt_d.armed = 1'b1;
        rt_d.stb   = (phase_i == HALF_P);
        if (los_in) begin
            rt_d.seen  = 1'b0;
            rt_d.rdata = 1'b0;
        end else if (phase_i == HALF_P) begin
            rt_d.rdata = rt_q.seen;
            rt_d.seen  = rise_i;
        end else begin
            rt_d.seen = rt_q.seen | rise_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rt_q <= '0;
        else        rt_q <= rt_d;
    end

    assign rdata_o = rt_q.rdata;
    assign stb_o   = rt_q.stb;

    // R7
    stb_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rt_q.armed && stb_o |-> $past(phase_i) == HALF_P);

    // R8
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rt_q.armed && !stb_o && !$past(los_in) |-> $stable(rdata_o));

    // R9
    los_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rt_q.armed && $past(los_in) |-> !rdata_o);
endmodule

// File: rtl/ones_clk_recover.sv
module ones_clk_recover #(
    parameter int SUB_PHASES = 16,
    parameter int NUM_CLKS   = 3
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       pulse_in,
    input  logic                                       los_in,
    output logic                                       rclk,
    output logic                                       bit_stb,
    output logic                                       rdata,
    output logic [$clog2(SUB_PHASES*NUM_CLKS)-1:0]     phase
);
    localparam int PHASES = SUB_PHASES * NUM_CLKS;
    localparam int PW     = $clog2(PHASES);

    logic          rise;
    logic [PW-1:0] phase_w;

    ocr_edge_det u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pulse_in (pulse_in),
        .los_in   (los_in),
        .rise_o   (rise)
    );

    ocr_phase_trk #(.PHASES(PHASES)) u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise_i  (rise),
        .phase_o (phase_w),
        .rclk_o  (rclk)
    );

    ocr_retime #(.PHASES(PHASES)) u_rt (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise_i  (rise),
        .los_in  (los_in),
        .phase_i (phase_w),
        .rdata_o (rdata),
        .stb_o   (bit_stb)
    );

    assign phase = phase_w;

    // R7
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |=> !bit_stb);
endmodule

// File: tb/sim_ones_clk_recover.sv
`timescale 1ns/1ps
module sim_ones_clk_recover;
    localparam int PH   = 48;
    localparam int HALF = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pulse_in = 1'b0;
    logic       los_in = 1'b0;
    logic       rclk, bit_stb, rdata;
    logic [5:0] phase;

    int checks = 0;
    int fails  = 0;
    int m_ph = 0, m_prev = 0, m_seen = 0, m_rdata = 0, m_stb = 0;

    ones_clk_recover u0 (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .los_in(los_in),
        .rclk(rclk), .bit_stb(bit_stb), .rdata(rdata), .phase(phase)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One reference cycle: drive, clock, advance the model, compare.
    task automatic cyc(input bit p, input bit l);
        int old, e;
        string tg;
        pulse_in = p;
        los_in   = l;
        @(posedge clk);
        #1;
        e   = (p && m_prev == 0 && !l) ? 1 : 0;
        old = m_ph;
        if (l)                        tg = "R9";
        else if (p && m_prev == 1)    tg = "R5";
        else                          tg = "R2";
        m_prev = p;
        if (e == 0 || old == 0) begin
            m_ph = (old + 1) % PH;
            if (e == 1) tg = "R4";
        end else if (old < HALF) begin
            m_ph = old;
            tg = "R3";
        end else begin
            m_ph = (old + 2) % PH;
            tg = "R4";
        end
        m_stb = (old == HALF) ? 1 : 0;
        if (l) begin
            m_seen = 0; m_rdata = 0;
        end else if (old == HALF) begin
            m_rdata = m_seen; m_seen = e;
        end else begin
            m_seen = m_seen | e;
        end
        chk(int'(phase) == m_ph, tg, int'(phase), m_ph);
        chk(int'(rclk) == ((m_ph < HALF) ? 1 : 0), "R6", int'(rclk), (m_ph < HALF) ? 1 : 0);
        chk(int'(bit_stb) == m_stb, "R7", int'(bit_stb), m_stb);
        chk(int'(rdata) == m_rdata, l ? "R9" : "R8", int'(rdata), m_rdata);
    endtask

    initial begin
        #(5.0 * 200000);
        fails++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset values
        chk(phase == 6'd0, "R1", int'(phase), 0);
        chk(rclk == 1'b1, "R1", int'(rclk), 1);
        chk(rdata == 1'b0, "R1", int'(rdata), 0);
        chk(bit_stb == 1'b0, "R1", int'(bit_stb), 0);
        rst_n = 1'b1;

        // R2 free run through two wraps
        for (int i = 0; i < 100; i++) cyc(1'b0, 1'b0);

        // R3 / R4 edge placed at every phase
        for (int k = 0; k < PH; k++) begin
            while (m_ph != k) cyc(1'b0, 1'b0);
            cyc(1'b1, 1'b0);
            cyc(1'b0, 1'b0);
        end

        // R5 held-high level yields a single correction
        for (int i = 0; i < 100; i++) cyc(1'b1, 1'b0);
        for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0);

        // R4 lock to a misaligned stream, then R8 retimed data
        for (int i = 0; i < 17; i++) cyc(1'b0, 1'b0);
        for (int b = 0; b < 80; b++) begin
            bit val;
            val = (b < 40) ? 1'b1 : (((b * 5 + 1) % 3) == 0);
            for (int c = 0; c < PH; c++) begin
                if (b >= 40 && c == 0)
                    chk(phase == 6'd0, "R4", int'(phase), 0);
                cyc(val && (c < 12), 1'b0);
                if (b >= 40 && bit_stb)
                    chk(rdata == val, "R8", int'(rdata), int'(val));
            end
        end

        // R9 loss of signal with pulses still present
        for (int i = 0; i < 150; i++) cyc((i % PH) < 12, 1'b1);
        chk(rdata == 1'b0, "R9", int'(rdata), 0);
        for (int i = 0; i < 100; i++) cyc(1'b0, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule